// File: doc/BRIEF.md
# Symmetric Bit-Stacking 6:3 Column Counter

This block counts how many of six equal-weight bits are set and gives the result as a three-bit binary number. It is meant for partial-product reduction trees, where one column's bits are compressed into sum, first-carry and second-carry bits. The block does not use a ripple of full adders. Each half of the six inputs is first compacted into a three-bit thermometer stack, with all of its ones packed at the low index. The two stacks are then combined symmetrically into a third thermometer vector. That vector flags how far the total exceeds three. The carry outputs come from these vectors through AND/OR logic only. The single exclusive-OR produces the sum bit, and it combines two even-parity flags.

Several independent counters (lanes) sit side by side, so that one instance can serve one slice of a reduction stage. A build parameter chooses between a purely combinational output and a version registered on the clock. The registered version is used for timing-driven placement.

Top module: `sym_stack_counter`

## Requirements
- R1: Each three-bit stacker outputs the OR, the majority and the AND of its inputs, at indices 0, 1 and 2. The output holds as many ones as the input, all packed at the low-index end.
- R2: Within a lane, input bits [2:0] form the first group and bits [5:3] form the second. The lane's 3-bit output is {C2, C1, S}, with S at bit 0, C1 at bit 1 and C2 at bit 2. Read as an unsigned number, it equals the count of ones among the six inputs (0 to 6).
- R3: C2 is 1 exactly when four or more of the lane's six inputs are 1.
- R4: C1 is 1 exactly when the lane's count is 2, 3 or 6.
- R5: S is 1 exactly when an odd number of the lane's six inputs are 1.
- R6: The merged vector is a thermometer code of the count minus three, floored at zero. C2 is its OR.
- R7: Lane n takes input bits [6n+5:6n] and drives output bits [3n+2:3n]. The lanes do not affect each other.
- R8: With OUT_REG=1, the output shows the count of the inputs present at the previous rising clock edge. A synchronous active-high reset clears every output bit to 0 at the next edge.
- R9: With OUT_REG=0, the output follows the inputs within the same cycle, with no clock involved.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset of the output register |
| col_bits | input | LANES*6 | Six equal-weight bits per lane |
| col_count | output | LANES*3 | Count {C2, C1, S} per lane |

## Verification
The bench builds two copies, both with LANES=2: one with OUT_REG=1 and one with OUT_REG=0. This exercises the registered path with its one-cycle latency and reset clearing, and the same-cycle combinational path, against the same stimulus. Two lanes make the lane mapping and lane isolation visible. The bench sweeps all 64 patterns on the first lane while the second lane gets a scrambled pattern. It then adds seeded random pairs and the all-zero, all-one and boundary counts of three and four.

// File: rtl/symstk_pkg.sv
package symstk_pkg;

    localparam int GRP_W     = 3;
    localparam int LANE_IN_W = 2 * GRP_W;
    localparam int CNT_W     = 3;

    typedef logic [GRP_W-1:0] stack3_t;

    typedef struct packed {
        logic c2;
        logic c1;
        logic s;
    } cnt3_t;

    // pack ones of a three-bit group to the low index
    function automatic stack3_t stack3(input logic [GRP_W-1:0] x);
        stack3_t y;
        y[0] = x[0] | x[1] | x[2];
        y[1] = (x[0] & x[1]) | (x[0] & x[2]) | (x[1] & x[2]);
        y[2] = x[0] & x[1] & x[2];
        return y;
    endfunction

    // true when a stack holds zero or two ones
    function automatic logic even_flag(input stack3_t y);
        return ~y[0] | (y[1] & ~y[2]);
    endfunction

    // symmetric merge: bit j set when stack lengths sum to at least j+4
    function automatic stack3_t merge_k(input stack3_t h, input stack3_t i);
        stack3_t k;
        for (int j = 0; j < GRP_W; j++) begin
            logic acc;
            acc = 1'b0;
            for (int a = -1; a < GRP_W; a++) begin
                int   b;
                logic ha;
                logic ib;
                b  = j + 2 - a;
                ha = (a < 0) ? 1'b1 : h[2'(a)];
                if (b >= -1 && b < GRP_W) begin
                    ib  = (b < 0) ? 1'b1 : i[2'(b)];
                    acc = acc | (ha & ib);
                end
            end
            k[j] = acc;
        end
        return k;
    endfunction

endpackage

// File: rtl/bs_stacker3.sv
module bs_stacker3
    import symstk_pkg::*;
(
    input  logic [GRP_W-1:0] x,
    output stack3_t          y
);

    assign y = stack3(x);

    always_comb begin
        if (!$isunknown(x)) begin
            // R1
            stk_thermo_chk: assert (!(y[2] && !y[1]) && !(y[1] && !y[0]))
                else $error("stack not packed toward index 0");
            // R1
            stk_ones_chk: assert ($countones(y) == $countones(x))
                else $error("stack changed the number of ones");
        end
    end

endmodule

// File: rtl/bs_merge.sv
module bs_merge
    import symstk_pkg::*;
(
    input  stack3_t h,
    input  stack3_t i,
    output stack3_t k
);

    assign k = merge_k(h, i);

    always_comb begin
        if (!$isunknown({h, i})) begin
            int over;
            over = $countones(h) + $countones(i) - 3;
            // R6
            k_thermo_chk: assert (k == ((over <= 0) ? 3'b000 :
                                        (over == 1) ? 3'b001 :
                                        (over == 2) ? 3'b011 : 3'b111))
                else $error("merged vector is not the excess thermometer");
        end
    end

endmodule

// File: rtl/bs_convert.sv
module bs_convert
    import symstk_pkg::*;
(
    input  stack3_t h,
    input  stack3_t i,
    input  stack3_t k,
    output cnt3_t   cnt
);

    logic any_k;
    logic two_plus;

    always_comb begin
        any_k    = |k;
        two_plus = h[1] | i[1] | (h[0] & i[0]);
        cnt.c2   = any_k;
        cnt.c1   = (two_plus & ~any_k) | (h[2] & i[2]);
        cnt.s    = even_flag(h) ^ even_flag(i);
    end

    always_comb begin
        if (!$isunknown({h, i, k})) begin
            // R3
            c2_range_chk: assert (cnt.c2 == (($countones(h) + $countones(i)) >= 4))
                else $error("upper carry disagrees with stack lengths");
            // R2
            sum_match_chk: assert (int'(cnt) == ($countones(h) + $countones(i)))
                else $error("count disagrees with stack lengths");
        end
    end

endmodule

// File: rtl/bs_counter63.sv
module bs_counter63
    import symstk_pkg::*;
(
    input  logic [LANE_IN_W-1:0] x,
    output cnt3_t                cnt
);

    stack3_t h_stk;
    stack3_t i_stk;
    stack3_t k_vec;

    bs_stacker3 u_stk_lo (
        .x (x[GRP_W-1:0]),
        .y (h_stk)
    );

    bs_stacker3 u_stk_hi (
        .x (x[LANE_IN_W-1:GRP_W]),
        .y (i_stk)
    );

    bs_merge u_merge (
        .h (h_stk),
        .i (i_stk),
        .k (k_vec)
    );

    bs_convert u_conv (
        .h   (h_stk),
        .i   (i_stk),
        .k   (k_vec),
        .cnt (cnt)
    );

endmodule

// File: rtl/sym_stack_counter.sv
module sym_stack_counter
    import symstk_pkg::*;
#(
    parameter int LANES   = 2,
    parameter bit OUT_REG = 1'b1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [LANES*6-1:0]     col_bits,
    output logic [LANES*3-1:0]     col_count
);

    localparam int IN_W  = LANES * LANE_IN_W;
    localparam int OUT_W = LANES * CNT_W;

    logic [OUT_W-1:0] comb_count;

    for (genvar n = 0; n < LANES; n++) begin : g_lane
        cnt3_t lane_cnt;

        bs_counter63 u_cnt (
            .x   (col_bits[n*LANE_IN_W +: LANE_IN_W]),
            .cnt (lane_cnt)
        );

        assign comb_count[n*CNT_W +: CNT_W] = lane_cnt;
    end

    if (OUT_REG) begin : g_reg
        logic [OUT_W-1:0] count_q;

        always_ff @(posedge clk) begin
            if (rst) count_q <= '0;
            else     count_q <= comb_count;
        end

        assign col_count = count_q;

        // R8
        reg_follow_chk: assert property (@(posedge clk) disable iff (rst)
            !$past(rst) |-> (col_count == $past(comb_count)))
            else $error("registered count is not last cycle's result");
    end else begin : g_comb
        assign col_count = comb_count;
    end

    logic unused_in_w;
    assign unused_in_w = (IN_W == LANES * 6);

endmodule

// File: tb/sym_stack_counter_bench.sv
module sym_stack_counter_bench;

    localparam int LANES = 2;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic [LANES*6-1:0]   col_bits = '0;
    logic [LANES*3-1:0]   cnt_reg;
    logic [LANES*3-1:0]   cnt_comb;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [LANES*6-1:0] prev_bits = '0;
    bit                 have_prev = 1'b0;

    always #10 clk = ~clk;

    sym_stack_counter #(.LANES(LANES), .OUT_REG(1'b1)) u_sym_stack_counter (
        .clk       (clk),
        .rst       (rst),
        .col_bits  (col_bits),
        .col_count (cnt_reg)
    );

    sym_stack_counter #(.LANES(LANES), .OUT_REG(1'b0)) u_sym_stack_counter_comb (
        .clk       (clk),
        .rst       (rst),
        .col_bits  (col_bits),
        .col_count (cnt_comb)
    );

    function automatic int ones6(input logic [5:0] v);
        int c = 0;
        for (int b = 0; b < 6; b++) c += int'(v[b]);
        return c;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // compare every lane of an output vector against the given inputs
    task automatic check_lanes(input string tag, input logic [LANES*3-1:0] outv,
                               input logic [LANES*6-1:0] inv);
        for (int n = 0; n < LANES; n++) begin
            int c;
            logic [2:0] f;
            c = ones6(inv[n*6 +: 6]);
            f = outv[n*3 +: 3];
            chk({tag, " R1 R2 R7 count"}, int'(f), c);
            chk({tag, " R3 R6 C2"}, int'(f[2]), int'(c >= 4));
            chk({tag, " R4 C1"}, int'(f[1]), int'(c == 2 || c == 3 || c == 6));
            chk({tag, " R5 S"}, int'(f[0]), c % 2);
        end
    endtask

    task automatic step(input logic [LANES*6-1:0] v);
        @(negedge clk);
        if (have_prev) check_lanes("R8 reg", cnt_reg, prev_bits);
        col_bits = v;
        #1;
        check_lanes("R9 comb", cnt_comb, v);
        prev_bits = v;
        have_prev = 1'b1;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        // reset state with busy inputs: R8
        col_bits = {LANES*6{1'b1}};
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R8 reset clears", int'(cnt_reg), 0);
        rst = 1'b0;

        // exhaustive sweep of lane 0, scrambled lane 1
        for (int v = 0; v < 64; v++) begin
            logic [5:0] lo;
            logic [5:0] hi;
            lo = 6'(v);
            hi = 6'((v * 37 + 11) & 63);
            step({hi, lo});
        end
        // lane 1 sweep with lane 0 held at all ones (R7 isolation)
        for (int v = 0; v < 64; v++) step({6'(v), 6'h3F});

        // boundary counts: 3 and 4, zero and full
        step({6'b000_111, 6'b111_000});
        step({6'b001_111, 6'b100_011});
        step('0);
        step({LANES*6{1'b1}});

        // seeded random pairs
        for (int r = 0; r < 300; r++) step(12'($urandom));

        // mid-run reset: R8
        @(negedge clk);
        check_lanes("R8 reg", cnt_reg, prev_bits);
        rst = 1'b1;
        col_bits = {LANES*6{1'b1}};
        @(negedge clk);
        chk("R8 sync reset", int'(cnt_reg), 0);
        rst = 1'b0;
        have_prev = 1'b0;
        step(12'h5A5);
        step(12'h000);
        @(negedge clk);
        check_lanes("R8 reg", cnt_reg, prev_bits);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule